// File: doc/BRIEF.md
# Strobe-Relative Interval Timer

This block measures time in system clock cycles against the rising edges of an external sample-and-hold strobe. Two asynchronous strobe lines enter the block. A select input chooses which one is observed. Each strobe passes through its own synchronizer and rising-edge detector. A saturating cycle counter runs underneath. When a measurement completes, the count is latched onto the result output and a one-cycle valid pulse marks it.

There are two measurement modes. In update-to-edge mode the counter restarts on a filter-update pulse. The next detected strobe rise then reports the cycles elapsed since that update. In period mode the counter restarts on every detected strobe rise, so each rise reports the spacing from the previous rise. A change of mode or strobe selection restarts the measurement, and the first edge after that change reports nothing.

Top module: `sh_interval_meter`

## Requirements
- R1: With `sel_b`=0 only rising edges of `strobe_a` are measured, and with `sel_b`=1 only those of `strobe_b`. Edges on the other line produce no result.
- R2: With `mode_period`=0, a qualifying edge reports k + SYNC_STAGES. Here k is the number of clock cycles from the edge that samples `upd_pulse` high to the edge that first samples the strobe high.
- R3: With `mode_period`=1, each qualifying edge reports the number of clock cycles between it and the previous detected rising edge.
- R4: Only rising edges count. A strobe held high, or a falling edge, starts or ends no measurement.
- R5: The count saturates at 2^CNT_W-1 and does not wrap.
- R6: `interval_valid` is high for exactly one cycle per result, one clock after the edge is detected. `interval` changes only together with that pulse and holds its value otherwise.
- R7: With `mode_period`=0, an edge that has no `upd_pulse` since the previous edge produces no result.
- R8: When `mode_period` or `sel_b` differs from its value on the previous cycle, the measurement restarts. The first detected edge afterwards produces no result.
- R9: While `rst_n` is low, and after reset, `interval_valid` is 0 and `interval` is 0.
- R10: With `mode_period`=0, if `upd_pulse` is high in the same cycle an edge is detected, that edge reports the interval from the earlier update. The new update then starts the next measurement from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a | input | 1 | Sample-and-hold strobe one (asynchronous) |
| strobe_b | input | 1 | Sample-and-hold strobe two (asynchronous) |
| sel_b | input | 1 | 0 selects strobe_a, 1 selects strobe_b |
| mode_period | input | 1 | 0: update-to-edge mode, 1: edge-to-edge period mode |
| upd_pulse | input | 1 | Single-cycle filter-update pulse |
| interval | output | CNT_W | Latched measured cycle count |
| interval_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench checks several corner cases. An update pulse and an edge that land in the same cycle are checked; a design that reloaded before reporting would give a tiny interval. Measurements that outlast the counter are checked; a wrapping counter would report a small number instead of the ceiling. A strobe held high for a long time and then released is checked; a design that reacted to the falling edge would emit a spurious result. Edges that follow a mode or select change, or arrive without a preceding update, are checked; a missing restart would report a stale or overlapping interval.

// File: rtl/sh_meter_pkg.sv
package sh_meter_pkg;
   typedef enum logic {
      MEAS_UPD_TO_EDGE = 1'b0,
      MEAS_PERIOD      = 1'b1
   } meas_mode_e;

   typedef struct packed {
      meas_mode_e mode;
      logic       sel;
   } meas_cfg_t;
endpackage

// File: rtl/sh_edge_sync.sv
module sh_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic sync_w;
   logic prev_q;

   generate
      if (STAGES > 0) begin : g_sync
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= din;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign sync_w = pipe_q[STAGES-1];
      end else begin : g_bypass
         assign sync_w = din;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_w;
   end

   assign rise = sync_w & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R4
endmodule

// File: rtl/sh_sat_counter.sv
module sh_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] CNT_ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= CNT_ONE;
      else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_ONE;
   end

   assign cnt = cnt_q;

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) && !load |=> cnt_q == CNT_MAX); // R5
   AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == CNT_ONE); // R2
endmodule

// File: rtl/sh_interval_ctrl.sv
module sh_interval_ctrl
   import sh_meter_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise_a,
   input  logic         rise_b,
   input  logic         sel_b,
   input  logic         mode_period,
   input  logic         upd_pulse,
   input  logic [W-1:0] cnt,
   output logic         load,
   output logic [W-1:0] interval,
   output logic         interval_valid
);
   meas_cfg_t    cfg_q, cfg_in;
   logic         chg, rise_sel, hit;
   logic         seen_q, armed_q, valid_q;
   logic [W-1:0] interval_q;

   assign cfg_in   = '{mode: meas_mode_e'(mode_period), sel: sel_b};
   assign chg      = (cfg_in != cfg_q);
   assign rise_sel = sel_b ? rise_b : rise_a;

   always_comb begin
      hit  = !chg && rise_sel && seen_q && (mode_period || armed_q);
      load = chg || (mode_period ? rise_sel : upd_pulse);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '{mode: MEAS_UPD_TO_EDGE, sel: 1'b0};
         seen_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (chg) begin
         cfg_q   <= cfg_in;
         seen_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (rise_sel)       seen_q  <= 1'b1;
         if (upd_pulse)      armed_q <= 1'b1;
         else if (rise_sel)  armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q    <= 1'b0;
         interval_q <= '0;
      end else begin
         valid_q <= hit;
         if (hit) interval_q <= cnt;
      end
   end

   assign interval       = interval_q;
   assign interval_valid = valid_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R6
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(interval_q)); // R6
   AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !valid_q); // R8
   AST_NEED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_period && !armed_q && !upd_pulse |=> !valid_q); // R7
endmodule

// File: rtl/sh_interval_meter.sv
module sh_interval_meter #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_a,
   input  logic             strobe_b,
   input  logic             sel_b,
   input  logic             mode_period,
   input  logic             upd_pulse,
   output logic [CNT_W-1:0] interval,
   output logic             interval_valid
);
   localparam int N_STROBE = 2;

   initial begin : p_param_chk
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic [N_STROBE-1:0] strobe_in, rise_v;
   logic                load;
   logic [CNT_W-1:0]    cnt;

   assign strobe_in = {strobe_b, strobe_a};

   generate
      for (genvar g = 0; g < N_STROBE; g++) begin : g_edge
         sh_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (strobe_in[g]),
            .rise (rise_v[g])
         );
      end
   endgenerate

   sh_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .cnt  (cnt)
   );

   sh_interval_ctrl #(.W(CNT_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .rise_a        (rise_v[0]),
      .rise_b        (rise_v[1]),
      .sel_b         (sel_b),
      .mode_period   (mode_period),
      .upd_pulse     (upd_pulse),
      .cnt           (cnt),
      .load          (load),
      .interval      (interval),
      .interval_valid(interval_valid)
   );
endmodule

// File: tb/sh_interval_meter_tb_top.sv
`timescale 1ns/1ps
module sh_interval_meter_tb_top;
   localparam int W    = 8;
   localparam int SYNC = 2;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe_a = 1'b0, strobe_b = 1'b0, sel_b = 1'b0, mode_period = 1'b0, upd_pulse = 1'b0;
   logic [W-1:0] interval;
   logic interval_valid;

   always #2 clk = ~clk;

   sh_interval_meter #(.CNT_W(W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
      .sel_b(sel_b), .mode_period(mode_period), .upd_pulse(upd_pulse),
      .interval(interval), .interval_valid(interval_valid)
   );

   int checks = 0, errors = 0, cyc = 0;
   int vcnt = 0, lastv = 0, run = 0, max_run = 0;
   string phase = "R9";

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference: queues hold synchronizer history
   bit qa[$], qb[$];
   bit pa, pb, m_mode, m_sel, m_seen, m_armed, e_valid;
   int m_cnt, e_int;

   always @(posedge clk) begin
      bit ra, rb, r, change, hit;
      if (!rst_n) begin
         qa = {}; qb = {};
         for (int i = 0; i < SYNC; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
         pa = 0; pb = 0; m_mode = 0; m_sel = 0; m_seen = 0; m_armed = 0;
         m_cnt = 0; e_valid = 0; e_int = 0;
      end else begin
         ra = qa[SYNC-1] && !pa;
         rb = qb[SYNC-1] && !pb;
         pa = qa[SYNC-1]; pb = qb[SYNC-1];
         qa.push_front(strobe_a); void'(qa.pop_back());
         qb.push_front(strobe_b); void'(qb.pop_back());
         r = sel_b ? rb : ra;
         change = (mode_period != m_mode) || (sel_b != m_sel);
         hit = !change && r && m_seen && (mode_period || m_armed);
         e_valid = hit;
         if (hit) e_int = m_cnt;
         if (change || (mode_period ? r : upd_pulse)) m_cnt = 1;
         else if (m_cnt < MAXV) m_cnt++;
         if (change) begin
            m_mode = mode_period; m_sel = sel_b; m_seen = 0; m_armed = 0;
         end else begin
            if (r) m_seen = 1;
            if (upd_pulse) m_armed = 1; else if (r) m_armed = 0;
         end
      end
      #1;
      cyc++;
      check(interval_valid == e_valid, {phase, " valid vs model"}, interval_valid, e_valid);
      check(int'(interval) == e_int, {phase, " interval vs model"}, interval, e_int);
      if (rst_n && interval_valid) begin
         vcnt++; lastv = interval; run++;
         if (run > max_run) max_run = run;
      end else run = 0;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input bit on_b, input int gap);
      if (on_b) strobe_b = 1'b1; else strobe_a = 1'b1;
      idle(3);
      if (on_b) strobe_b = 1'b0; else strobe_a = 1'b0;
      idle(gap - 3);
   endtask

   initial begin
      int v0;
      idle(3);
      check(interval_valid == 1'b0, "R9 reset valid", interval_valid, 0);
      check(interval == '0, "R9 reset interval", interval, 0);
      rst_n = 1'b1;
      idle(3);

      // R3: period mode, strobe_a every 10 cycles
      phase = "R3"; mode_period = 1'b1; idle(5);
      v0 = vcnt;
      repeat (4) pulse(1'b0, 10);
      idle(5);
      check(vcnt - v0 == 3, "R3 result count", vcnt - v0, 3);
      check(lastv == 10, "R3 period value", lastv, 10);
      check(max_run == 1, "R6 single-cycle valid", max_run, 1);

      // R1: unselected strobe ignored, then select strobe_b
      phase = "R1"; v0 = vcnt;
      repeat (3) pulse(1'b1, 9);
      idle(5);
      check(vcnt - v0 == 0, "R1 unselected strobe ignored", vcnt - v0, 0);
      sel_b = 1'b1; idle(3);
      v0 = vcnt;
      repeat (3) pulse(1'b1, 9);
      idle(5);
      check(vcnt - v0 == 2, "R8 first edge after select change suppressed", vcnt - v0, 2);
      check(lastv == 9, "R1 strobe_b period", lastv, 9);

      // R4: long high then low, falling edge ignored
      phase = "R4";
      strobe_b = 1'b1; idle(30);
      v0 = vcnt;
      strobe_b = 1'b0; idle(20);
      check(vcnt - v0 == 0, "R4 falling edge gives no result", vcnt - v0, 0);
      pulse(1'b1, 10);
      check(lastv == 50, "R4 rise-to-rise across long high", lastv, 50);

      // R5: saturation
      phase = "R5";
      pulse(1'b1, 300); pulse(1'b1, 300); idle(5);
      check(lastv == MAXV, "R5 saturated count", lastv, MAXV);

      // R2 / R8: update-to-edge mode on strobe_a
      phase = "R2"; mode_period = 1'b0; sel_b = 1'b0; idle(5);
      v0 = vcnt;
      pulse(1'b0, 10);
      check(vcnt - v0 == 0, "R8 first edge after mode change suppressed", vcnt - v0, 0);
      upd_pulse = 1'b1; @(negedge clk); upd_pulse = 1'b0;
      idle(4);
      v0 = vcnt;
      pulse(1'b0, 10);
      check(vcnt - v0 == 1, "R2 result produced", vcnt - v0, 1);
      check(lastv == 5 + SYNC, "R2 update to edge value", lastv, 5 + SYNC);

      // R7: edge with no update
      phase = "R7"; v0 = vcnt;
      pulse(1'b0, 12);
      check(vcnt - v0 == 0, "R7 no update no result", vcnt - v0, 0);

      // R10: update coincides with detection
      phase = "R10";
      upd_pulse = 1'b1; @(negedge clk); upd_pulse = 1'b0;
      idle(4);
      v0 = vcnt;
      strobe_a = 1'b1; idle(2);
      upd_pulse = 1'b1; @(negedge clk); upd_pulse = 1'b0;
      strobe_a = 1'b0; @(negedge clk);
      check(lastv == 5 + SYNC, "R10 coincident edge reports earlier update", lastv, 5 + SYNC);
      idle(5);
      strobe_a = 1'b1; idle(3); strobe_a = 1'b0; idle(5);
      check(vcnt - v0 == 2, "R10 new update measured", vcnt - v0, 2);
      check(lastv == 9, "R10 interval from coincident update", lastv, 9);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule